// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block decides when an on-chip debug session fires. Three comparator channels report address matches. Each channel runs in one of two modes. In forced mode a match acts a fixed three cycles after the matching bus cycle. In tagged mode a match only marks the fetched instruction, and it acts when that instruction reaches execution. A small FIFO holds one tag entry per fetch. Each execution report pops the oldest entry, and a queue flush discards every pending entry.

While armed, the sequencer walks through three intermediate states. A configuration word gives, for each of those states and each channel, the state to move to when that channel matches. A software trigger can be written together with arm and disarm bits. It either jumps to the final state, where tracing is active, or ends the session with a one-cycle breakpoint request, depending on the alignment input. Each transition records in a flag register which source caused it.

Top module: `trig_seq`

## Requirements
- R1: After reset, `seqState` is 0 (disarmed), `statusFlags` is 0, and both `traceActive` and `brkReq` are 0.
- R2: State codes are 0 disarmed, 1, 2, 3 (intermediate states) and 4 final. A write with arm=1 and trig=0 moves to state 1 on the next cycle from any state. A write with arm=0 and trig=0 moves to state 0.
- R3: A forced-mode channel match sampled at a rising edge changes `seqState` exactly 3 cycles later. The new state is taken from the current state's target field for that channel.
- R4: A tagged-mode channel match does nothing when it is fetched. Its entry is queued in fetch order. The transition happens one cycle after the `execValid` that pops that entry, and an entry with no tag bits causes no transition.
- R5: A `flush` discards every queued tag, so a later `execValid` causes no transition.
- R6: Channel matches are ignored in state 0 and in state 4.
- R7: The target for state s (1..3) and channel c sits at `nextCfg[((s-1)*3+c)*3 +: 3]`. Values 1 to 4 name a state. Values 0, 5, 6 and 7 mean that channel causes no transition in that state.
- R8: `statusFlags` bit c (0..2) is set when channel c causes a transition, and bit 3 is set by a software trigger. Flags accumulate until a write with arm=1 clears them. A write with both arm and trig leaves only bit 3 set.
- R9: When matches coincide, only one acts. A channel whose target is 4 beats all other channels, and after that the lower channel number wins. The losing matches are dropped.
- R10: With `endAlign`=0, a software trigger or a transition into state 4 gives state 4, with `traceActive`=1.
- R11: With `endAlign`=1, a software trigger or a transition aimed at state 4 instead goes to state 0 and pulses `brkReq` for one cycle.
- R12: A software trigger (trig=1) acts only when the sequencer is not in state 0, or when arm=1 is written in the same write. Trig alone in state 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Control register write strobe |
| regArm | input | 1 | Arm bit of the write |
| regTrig | input | 1 | Software trigger bit of the write |
| endAlign | input | 1 | 1 = end-aligned session, 0 = begin-aligned |
| tagMode | input | 3 | Per channel: 1 = tagged, 0 = forced |
| nextCfg | input | 27 | Target state per intermediate state and channel |
| addrMatch | input | 3 | Comparator match pulses, one per channel |
| fetchValid | input | 1 | An instruction is fetched this cycle |
| execValid | input | 1 | The oldest fetched instruction reaches execution |
| flush | input | 1 | Instruction queue flush |
| seqState | output | 3 | Current sequencer state code |
| statusFlags | output | 4 | Transition source flags |
| traceActive | output | 1 | High in the final state |
| brkReq | output | 1 | One-cycle forced breakpoint request |

## Verification
A faulty state register shows on `seqState` at the next edge, and a bad transition choice shows one cycle after the winning match reaches the controller. Faults in the forced delay line show as transitions one cycle early or late. Faults in the tag FIFO show as a transition on the wrong `execValid` pulse, or a stale one after a flush. A bad priority or flag update shows in `statusFlags` in the same cycle as the faulty state change.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int NUM_CH  = 3;
  localparam int NUM_SEQ = 3;
  localparam int STATE_W = 3;
  localparam int FLAG_W  = NUM_CH + 1;
  localparam int CFG_W   = NUM_SEQ * NUM_CH * STATE_W;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_FINAL = 3'd4
  } seqState_t;

  typedef struct packed {
    logic              clrFlags;
    logic [FLAG_W-1:0] setFlags;
  } ctrlStrobe_t;
endpackage

// File: rtl/trig_seq_dp.sv
module trig_seq_dp
  import trig_seq_pkg::*;
#(
  parameter int FORCE_DELAY = 3,
  parameter int TAG_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] addrMatch,
  input  logic [NUM_CH-1:0] tagMode,
  input  logic              fetchValid,
  input  logic              execValid,
  input  logic              flush,
  input  ctrlStrobe_t       strobe,
  output logic [NUM_CH-1:0] chanHit,
  output logic [FLAG_W-1:0] flags
);
  localparam int PTR_W = (TAG_DEPTH > 1) ? $clog2(TAG_DEPTH) : 1;
  localparam int CNT_W = $clog2(TAG_DEPTH + 1);

  // forced-match delay line
  logic [NUM_CH-1:0] pipeQ [FORCE_DELAY];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FORCE_DELAY; i++) pipeQ[i] <= '0;
    end else begin
      pipeQ[0] <= addrMatch & ~tagMode;
      for (int i = 1; i < FORCE_DELAY; i++) pipeQ[i] <= pipeQ[i-1];
    end
  end

  // tag FIFO in fetch order
  logic [NUM_CH-1:0] tagMem [TAG_DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  tagCount;
  logic              popEn, pushEn;
  logic [NUM_CH-1:0] tagHit;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(TAG_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign popEn  = execValid && !flush && (tagCount != '0);
  assign pushEn = fetchValid && !flush && ((tagCount != CNT_W'(TAG_DEPTH)) || popEn);
  assign tagHit = popEn ? tagMem[rdPtr] : '0;

  always_ff @(posedge clk) begin
    if (pushEn) tagMem[wrPtr] <= addrMatch & tagMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      tagCount <= '0;
    end else begin
      if (pushEn) wrPtr <= bump(wrPtr);
      if (popEn)  rdPtr <= bump(rdPtr);
      case ({pushEn, popEn})
        2'b10:   tagCount <= tagCount + 1'b1;
        2'b01:   tagCount <= tagCount - 1'b1;
        default: tagCount <= tagCount;
      endcase
    end
  end

  assign chanHit = pipeQ[FORCE_DELAY-1] | tagHit;

  // status flags
  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (strobe.clrFlags ? '0 : flags) | strobe.setFlags;
  end

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (tagCount == '0));
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    tagCount <= CNT_W'(TAG_DEPTH));
  assert_flags_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrFlags |=> ((flags & ~$past(strobe.setFlags)) == '0));
endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic              regArm,
  input  logic              regTrig,
  input  logic              endAlign,
  input  logic [CFG_W-1:0]  nextCfg,
  input  logic [NUM_CH-1:0] chanHit,
  output seqState_t         stateQ,
  output ctrlStrobe_t       strobe,
  output logic              brkReq
);
  logic                 armed, trigFire, anyWin;
  logic [STATE_W-1:0]   tgt [NUM_CH];
  logic [NUM_CH-1:0]    valid, finalHit;
  int                   selIdx, winIdx;
  seqState_t            stateD;
  logic                 brkD;

  assign armed    = (stateQ != ST_IDLE) && (stateQ != ST_FINAL);
  assign trigFire = regWrite && regTrig && (regArm || stateQ != ST_IDLE);
  assign selIdx   = armed ? int'(stateQ) - 1 : 0;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      tgt[c]      = armed ? nextCfg[(selIdx*NUM_CH + c)*STATE_W +: STATE_W] : '0;
      valid[c]    = chanHit[c] && (tgt[c] >= ST_ONE) && (tgt[c] <= ST_FINAL);
      finalHit[c] = valid[c] && (tgt[c] == ST_FINAL);
    end
  end

  // priority: final-bound channel first, then lowest channel number
  always_comb begin
    winIdx = 0;
    for (int c = NUM_CH - 1; c >= 0; c--) if (valid[c])    winIdx = c;
    for (int c = NUM_CH - 1; c >= 0; c--) if (finalHit[c]) winIdx = c;
  end
  assign anyWin = |valid;

  always_comb begin
    stateD = stateQ;
    brkD   = 1'b0;
    strobe = '0;
    if (regWrite && regArm) begin
      stateD          = ST_ONE;
      strobe.clrFlags = 1'b1;
    end else if (regWrite && !regTrig) begin
      stateD = ST_IDLE;
    end
    if (trigFire) begin
      strobe.setFlags[NUM_CH] = 1'b1;
      if (endAlign) begin
        stateD = ST_IDLE;
        brkD   = 1'b1;
      end else begin
        stateD = ST_FINAL;
      end
    end else if (!regWrite && anyWin) begin
      strobe.setFlags[winIdx] = 1'b1;
      if (tgt[winIdx] == ST_FINAL && endAlign) begin
        stateD = ST_IDLE;
        brkD   = 1'b1;
      end else begin
        stateD = seqState_t'(tgt[winIdx]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      brkReq <= 1'b0;
    end else begin
      stateQ <= stateD;
      brkReq <= brkD;
    end
  end

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !regWrite) |=> (stateQ == ST_IDLE));
  assert_final_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_FINAL && !regWrite) |=> (stateQ == ST_FINAL));
  assert_brk_disarmed_R11: assert property (@(posedge clk) disable iff (!rstN)
    brkReq |-> (stateQ == ST_IDLE));
  assert_single_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobe.setFlags) <= 1);
  assert_arm_enters_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regArm && !regTrig) |=> (stateQ == ST_ONE));
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int FORCE_DELAY = 3,
  parameter int TAG_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic              regArm,
  input  logic              regTrig,
  input  logic              endAlign,
  input  logic [NUM_CH-1:0] tagMode,
  input  logic [CFG_W-1:0]  nextCfg,
  input  logic [NUM_CH-1:0] addrMatch,
  input  logic              fetchValid,
  input  logic              execValid,
  input  logic              flush,
  output logic [STATE_W-1:0] seqState,
  output logic [FLAG_W-1:0] statusFlags,
  output logic              traceActive,
  output logic              brkReq
);
  ctrlStrobe_t       strobe;
  logic [NUM_CH-1:0] chanHit;
  seqState_t         stateQ;

  trig_seq_dp #(.FORCE_DELAY(FORCE_DELAY), .TAG_DEPTH(TAG_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .addrMatch(addrMatch), .tagMode(tagMode),
    .fetchValid(fetchValid), .execValid(execValid), .flush(flush),
    .strobe(strobe), .chanHit(chanHit), .flags(statusFlags)
  );

  trig_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regArm(regArm),
    .regTrig(regTrig), .endAlign(endAlign), .nextCfg(nextCfg),
    .chanHit(chanHit), .stateQ(stateQ), .strobe(strobe), .brkReq(brkReq)
  );

  assign seqState    = stateQ;
  assign traceActive = (stateQ == ST_FINAL);
endmodule

// File: tb/test_trig_seq.sv
`timescale 1ns/1ps
module test_trig_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 0, regArm = 0, regTrig = 0, endAlign = 0;
  logic [2:0]  tagMode = '0;
  logic [26:0] nextCfg = '0;
  logic [2:0]  addrMatch = '0;
  logic        fetchValid = 0, execValid = 0, flush = 0;
  logic [2:0]  seqState;
  logic [3:0]  statusFlags;
  logic        traceActive, brkReq;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic done = 1'b0;

  typedef struct {
    int         at;
    logic [2:0] st;
    logic [3:0] fl;
    logic       brk;
    logic       tr;
    string      req;
  } expItem_t;
  expItem_t expQ[$];

  trig_seq i_trig_seq (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regArm(regArm),
    .regTrig(regTrig), .endAlign(endAlign), .tagMode(tagMode),
    .nextCfg(nextCfg), .addrMatch(addrMatch), .fetchValid(fetchValid),
    .execValid(execValid), .flush(flush), .seqState(seqState),
    .statusFlags(statusFlags), .traceActive(traceActive), .brkReq(brkReq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares outputs 2 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (expQ.size() > 0 && expQ[0].at <= cyc) begin
        expItem_t e;
        e = expQ.pop_front();
        tests++;
        if (e.at < cyc) begin
          fails++;
          $display("FAIL %s missed sample cycle actual=%0d expected=%0d", e.req, cyc, e.at);
        end else if (seqState !== e.st || statusFlags !== e.fl ||
                     brkReq !== e.brk || traceActive !== e.tr) begin
          fails++;
          $display("FAIL %s cyc %0d actual st=%0d fl=%b brk=%b tr=%b expected st=%0d fl=%b brk=%b tr=%b",
                   e.req, cyc, seqState, statusFlags, brkReq, traceActive,
                   e.st, e.fl, e.brk, e.tr);
        end
      end
    end
  end

  task automatic expectAt(int at, logic [2:0] st, logic [3:0] fl,
                          logic brk, logic tr, string req);
    expItem_t e;
    e.at = at; e.st = st; e.fl = fl; e.brk = brk; e.tr = tr; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic drive(logic w, logic a, logic t, logic [2:0] am,
                       logic fv, logic ev, logic fl);
    regWrite = w; regArm = a; regTrig = t; addrMatch = am;
    fetchValid = fv; execValid = ev; flush = fl;
    @(negedge clk);
    regWrite = 0; regArm = 0; regTrig = 0; addrMatch = '0;
    fetchValid = 0; execValid = 0; flush = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setTarget(int s, int c, logic [2:0] v);
    nextCfg[((s-1)*3 + c)*3 +: 3] = v;
  endtask

  initial begin
    // R7 target layout
    setTarget(1, 0, 3'd2); setTarget(1, 1, 3'd3); setTarget(1, 2, 3'd4);
    setTarget(2, 0, 3'd3); setTarget(2, 1, 3'd1); setTarget(2, 2, 3'd0);
    setTarget(3, 0, 3'd4); setTarget(3, 1, 3'd1); setTarget(3, 2, 3'd2);
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    tests++;
    if (seqState !== 3'd0 || statusFlags !== 4'd0 || brkReq !== 1'b0 || traceActive !== 1'b0) begin
      fails++;
      $display("FAIL R1 actual st=%0d fl=%b brk=%b tr=%b expected 0 0000 0 0",
               seqState, statusFlags, brkReq, traceActive);
    end

    // R6 forced match while disarmed
    expectAt(cyc + 4, 3'd0, 4'b0000, 0, 0, "R6 disarmed");
    drive(0, 0, 0, 3'b001, 0, 0, 0); idle(4);

    // R2 arm
    expectAt(cyc + 1, 3'd1, 4'b0000, 0, 0, "R2 arm");
    drive(1, 1, 0, 3'b000, 0, 0, 0); idle(1);

    // R3 forced delay 3 cycles
    expectAt(cyc + 3, 3'd1, 4'b0000, 0, 0, "R3 not early");
    expectAt(cyc + 4, 3'd2, 4'b0001, 0, 0, "R3 forced ch0");
    drive(0, 0, 0, 3'b001, 0, 0, 0); idle(4);

    // R4 tagged: no action at fetch, acts on its own exec
    tagMode = 3'b010;
    drive(0, 0, 0, 3'b000, 1, 0, 0);
    drive(0, 0, 0, 3'b010, 1, 0, 0);
    expectAt(cyc + 4, 3'd2, 4'b0001, 0, 0, "R4 no action at fetch");
    idle(5);
    expectAt(cyc + 1, 3'd2, 4'b0001, 0, 0, "R4 untagged entry");
    drive(0, 0, 0, 3'b000, 0, 1, 0);
    expectAt(cyc + 1, 3'd1, 4'b0011, 0, 0, "R4 tagged exec");
    drive(0, 0, 0, 3'b000, 0, 1, 0); idle(1);

    // R5 flush drops pending tag
    drive(0, 0, 0, 3'b010, 1, 0, 0);
    drive(0, 0, 0, 3'b000, 0, 0, 1);
    expectAt(cyc + 1, 3'd1, 4'b0011, 0, 0, "R5 flushed tag");
    drive(0, 0, 0, 3'b000, 0, 1, 0); idle(1);
    tagMode = 3'b000;

    // R7 target 0 means no transition
    expectAt(cyc + 4, 3'd2, 4'b0011, 0, 0, "R3 forced to state 2");
    drive(0, 0, 0, 3'b001, 0, 0, 0); idle(4);
    expectAt(cyc + 4, 3'd2, 4'b0011, 0, 0, "R7 null target");
    drive(0, 0, 0, 3'b100, 0, 0, 0); idle(4);

    // R9 lower channel wins
    expectAt(cyc + 1, 3'd1, 4'b0000, 0, 0, "R8 arm clears flags");
    drive(1, 1, 0, 3'b000, 0, 0, 0);
    expectAt(cyc + 4, 3'd2, 4'b0001, 0, 0, "R9 lower index wins");
    drive(0, 0, 0, 3'b011, 0, 0, 0); idle(4);

    // R9 final-bound wins, R10 begin-aligned final
    expectAt(cyc + 1, 3'd1, 4'b0000, 0, 0, "R2 rearm");
    drive(1, 1, 0, 3'b000, 0, 0, 0);
    expectAt(cyc + 4, 3'd4, 4'b0100, 0, 1, "R9 final-bound wins");
    drive(0, 0, 0, 3'b101, 0, 0, 0); idle(4);
    expectAt(cyc + 4, 3'd4, 4'b0100, 0, 1, "R6 final ignores match");
    drive(0, 0, 0, 3'b001, 0, 0, 0); idle(4);

    // R10 software trigger begin-aligned
    expectAt(cyc + 1, 3'd1, 4'b0000, 0, 0, "R2 arm from final");
    drive(1, 1, 0, 3'b000, 0, 0, 0);
    expectAt(cyc + 4, 3'd2, 4'b0001, 0, 0, "R3 forced ch0 again");
    drive(0, 0, 0, 3'b001, 0, 0, 0); idle(4);
    expectAt(cyc + 1, 3'd4, 4'b1001, 0, 1, "R10 sw trigger");
    drive(1, 0, 1, 3'b000, 0, 0, 0); idle(1);

    // R2 disarm, R12 trig alone ignored when disarmed
    expectAt(cyc + 1, 3'd0, 4'b1001, 0, 0, "R2 disarm");
    drive(1, 0, 0, 3'b000, 0, 0, 0);
    expectAt(cyc + 1, 3'd0, 4'b1001, 0, 0, "R12 trig alone ignored");
    drive(1, 0, 1, 3'b000, 0, 0, 0); idle(1);

    // R11/R12 end-aligned immediate trigger
    endAlign = 1'b1;
    expectAt(cyc + 1, 3'd0, 4'b1000, 1, 0, "R12 trig+arm immediate");
    expectAt(cyc + 2, 3'd0, 4'b1000, 0, 0, "R11 brk one cycle");
    drive(1, 1, 1, 3'b000, 0, 0, 0); idle(2);

    // R11 channel to final in end-aligned session
    expectAt(cyc + 1, 3'd1, 4'b0000, 0, 0, "R2 arm end-aligned");
    drive(1, 1, 0, 3'b000, 0, 0, 0);
    expectAt(cyc + 4, 3'd0, 4'b0100, 1, 0, "R11 channel end-aligned");
    expectAt(cyc + 5, 3'd0, 4'b0100, 0, 0, "R11 brk drops");
    drive(0, 0, 0, 3'b100, 0, 0, 0); idle(6);

    while (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      tests++; fails++;
      $display("FAIL %s never sampled actual=none expected=cycle %0d", e.req, e.at);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule